// File: doc/BRIEF.md
# Register-Memory Operand Locator

This block takes the addressing byte that follows an opcode and works out where the operand lives. When the two mode bits select a register operand, it reports a register index built from the width bit and the low three bits of the byte. Otherwise it forms a 16-bit effective offset and adds it to a shifted segment base to give a 20-bit physical address. The offset comes from base and index registers, an optional displacement, or a direct displacement alone.

The segment defaults to the stack segment for forms built on the frame-base register and to the data segment for all other forms. A valid segment-override prefix byte replaces the default. The instruction sequencer feeds in the addressing byte, the width bit, the displacement field and the current pointer and segment register values. It reads the result one clock later, because the outputs sit behind a register stage. With `OUT_REG` set to 0 the outputs become purely combinational.

Top module: `operand_locator`

## Requirements
- R1: `reg_mode_o` is 1 exactly when bits 7:6 of the addressing byte equal 11, and 0 for the three memory encodings 00, 01 and 10.
- R2: In register mode, `reg_idx_o` equals {width bit, bits 2:0}. Codes 0..7 name the byte registers AL, CL, DL, BL, AH, CH, DH, BH and codes 8..15 name the word registers AX, CX, DX, BX, SP, BP, SI, DI. In memory mode, `reg_idx_o` is 0.
- R3: In every mode, `reg_sel_o` equals {width bit, bits 5:3}, using the same register numbering as R2.
- R4: In register mode, `offset_o` and `phys_o` are 0 and `seg_code_o` is 11.
- R5: In memory mode, bits 2:0 pick the base sum: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX.
- R6: Mode 00 adds no displacement. Mode 01 adds the low byte of `disp_i`, sign-extended to 16 bits. Mode 10 adds all of `disp_i`. The offset wraps modulo 65536.
- R7: Mode 00 with bits 2:0 equal to 110 gives an offset equal to `disp_i` with no base register, and the default segment is the data segment.
- R8: Segment codes are 00 ES, 01 CS, 10 SS and 11 DS. Without an override, the forms 010, 011, and 110 in modes 01 or 10, select SS (10). Every other memory form selects DS (11).
- R9: When `pfx_vld_i` is 1 and `pfx_i` matches the pattern 001rr110, `seg_code_o` equals rr in memory mode.
- R10: A prefix is ignored when `pfx_vld_i` is 0 or when any of the bits 7:5 or 2:0 of `pfx_i` differ from the pattern. In that case the default segment of R8 applies.
- R11: In memory mode, `phys_o` equals (selected segment value × 16 + `offset_o`) modulo 2^20.
- R12: With `OUT_REG` = 1, each output reflects the inputs present at the previous rising edge. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modrm_i | input | 8 | Addressing byte: mode 7:6, register field 5:3, operand select 2:0 |
| wide_i | input | 1 | Width bit, 1 for word operands |
| disp_i | input | 16 | Displacement field; only the low byte is used in mode 01 |
| bx_i | input | 16 | Base register value |
| bp_i | input | 16 | Frame-base register value |
| si_i | input | 16 | Source index value |
| di_i | input | 16 | Destination index value |
| es_i | input | 16 | Extra segment value |
| cs_i | input | 16 | Code segment value |
| ss_i | input | 16 | Stack segment value |
| ds_i | input | 16 | Data segment value |
| pfx_i | input | 8 | Candidate segment-override prefix byte |
| pfx_vld_i | input | 1 | Prefix byte present |
| reg_mode_o | output | 1 | Operand is a register |
| reg_idx_o | output | 4 | Register index of the selected operand |
| reg_sel_o | output | 4 | Register index named by the register field |
| offset_o | output | 16 | Effective offset |
| seg_code_o | output | 2 | Selected segment code |
| phys_o | output | 20 | Physical address |

## Verification
The block holds no state beyond its output register, so any wrong decode shows up on the edge right after the inputs are applied and is gone on the next one. A bad base-table entry corrupts only `offset_o`, and through it `phys_o`, for a single operand-select code. A wrong segment choice leaves `offset_o` intact but moves `phys_o` by a multiple of 16 and changes `seg_code_o`. The stimulus therefore walks every operand-select code in each mode and holds distinct, non-overlapping register values, so each mistake produces a different value at the ports.

// File: rtl/oploc_pkg.sv
package oploc_pkg;

  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_code_e;

  typedef enum logic [1:0] {
    MD_NODISP = 2'b00,
    MD_DISP8  = 2'b01,
    MD_DISP16 = 2'b10,
    MD_REG    = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic [2:0] reg_f;
    logic [2:0] rm;
  } modrm_t;

  // override prefix pattern: 001 rr 110
  localparam logic [2:0] PFX_HEAD = 3'b001;
  localparam logic [2:0] PFX_TAIL = 3'b110;
  localparam logic [2:0] RM_DIRECT = 3'b110;

endpackage

// File: rtl/oploc_field_split.sv
module oploc_field_split
  import oploc_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [7:0]        modrm_i,
  input  logic [WORD_W-1:0] disp_i,
  output mode_e             mode_o,
  output logic [2:0]        rm_o,
  output logic [2:0]        regf_o,
  output logic              reg_mode_o,
  output logic              direct_o,
  output logic [WORD_W-1:0] disp_ext_o
);
  localparam int EXT_W = WORD_W - SHORT_W;

  modrm_t fields;
  logic   short_sign;

  assign fields     = modrm_t'(modrm_i);
  assign mode_o     = fields.mode;
  assign rm_o       = fields.rm;
  assign regf_o     = fields.reg_f;
  assign reg_mode_o = (fields.mode == MD_REG);
  assign direct_o   = (fields.mode == MD_NODISP) && (fields.rm == RM_DIRECT);
  assign short_sign = disp_i[SHORT_W-1];

  always_comb begin
    unique case (fields.mode)
      MD_DISP8:  disp_ext_o = {{EXT_W{short_sign}}, disp_i[SHORT_W-1:0]};
      MD_DISP16: disp_ext_o = disp_i;
      MD_NODISP: disp_ext_o = direct_o ? disp_i : '0;
      default:   disp_ext_o = '0;
    endcase
  end

endmodule

// File: rtl/oploc_offset_calc.sv
module oploc_offset_calc #(
  parameter int WORD_W = 16
) (
  input  logic [2:0]        rm_i,
  input  logic              direct_i,
  input  logic              reg_mode_i,
  input  logic [WORD_W-1:0] disp_ext_i,
  input  logic [WORD_W-1:0] bx_i,
  input  logic [WORD_W-1:0] bp_i,
  input  logic [WORD_W-1:0] si_i,
  input  logic [WORD_W-1:0] di_i,
  output logic [WORD_W-1:0] offset_o,
  output logic              uses_bp_o
);
  logic [WORD_W-1:0] base_a;
  logic [WORD_W-1:0] base_b;

  // base_a carries BX/BP, base_b carries SI/DI; either may be empty
  always_comb begin
    base_a    = '0;
    base_b    = '0;
    uses_bp_o = 1'b0;
    if (!rm_i[2]) begin
      base_a    = rm_i[1] ? bp_i : bx_i;
      base_b    = rm_i[0] ? di_i : si_i;
      uses_bp_o = rm_i[1];
    end else begin
      unique case (rm_i[1:0])
        2'b00: base_b = si_i;
        2'b01: base_b = di_i;
        2'b10: begin
          if (!direct_i) begin
            base_a    = bp_i;
            uses_bp_o = 1'b1;
          end
        end
        default: base_a = bx_i;
      endcase
    end
  end

  always_comb begin
    if (reg_mode_i) offset_o = '0;
    else            offset_o = base_a + base_b + disp_ext_i;
  end

endmodule

// File: rtl/oploc_seg_select.sv
module oploc_seg_select
  import oploc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              uses_bp_i,
  input  logic              reg_mode_i,
  input  logic [7:0]        pfx_i,
  input  logic              pfx_vld_i,
  input  logic [WORD_W-1:0] es_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] ds_i,
  output seg_code_e         code_o,
  output logic [WORD_W-1:0] base_o
);
  logic      pfx_hit;
  seg_code_e dflt;

  assign pfx_hit = pfx_vld_i && (pfx_i[7:5] == PFX_HEAD) && (pfx_i[2:0] == PFX_TAIL);
  assign dflt    = uses_bp_i ? SEG_SS : SEG_DS;

  always_comb begin
    if (reg_mode_i)   code_o = SEG_DS;
    else if (pfx_hit) code_o = seg_code_e'(pfx_i[4:3]);
    else              code_o = dflt;
  end

  always_comb begin
    unique case (code_o)
      SEG_ES:  base_o = es_i;
      SEG_CS:  base_o = cs_i;
      SEG_SS:  base_o = ss_i;
      default: base_o = ds_i;
    endcase
  end

endmodule

// File: rtl/operand_locator.sv
module operand_locator
  import oploc_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter bit OUT_REG   = 1'b1,
  localparam int PHYS_W   = WORD_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        modrm_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] disp_i,
  input  logic [WORD_W-1:0] bx_i,
  input  logic [WORD_W-1:0] bp_i,
  input  logic [WORD_W-1:0] si_i,
  input  logic [WORD_W-1:0] di_i,
  input  logic [WORD_W-1:0] es_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] ds_i,
  input  logic [7:0]        pfx_i,
  input  logic              pfx_vld_i,
  output logic              reg_mode_o,
  output logic [3:0]        reg_idx_o,
  output logic [3:0]        reg_sel_o,
  output logic [WORD_W-1:0] offset_o,
  output logic [1:0]        seg_code_o,
  output logic [PHYS_W-1:0] phys_o
);
  mode_e             mode;
  logic [2:0]        rm;
  logic [2:0]        regf;
  logic              reg_mode;
  logic              direct;
  logic [WORD_W-1:0] disp_ext;
  logic [WORD_W-1:0] offset;
  logic              uses_bp;
  seg_code_e         seg_code;
  logic [WORD_W-1:0] seg_base;
  logic [PHYS_W-1:0] phys;
  logic [3:0]        reg_idx;
  logic [3:0]        reg_sel;

  oploc_field_split #(.WORD_W(WORD_W)) u_split (
    .modrm_i    (modrm_i),
    .disp_i     (disp_i),
    .mode_o     (mode),
    .rm_o       (rm),
    .regf_o     (regf),
    .reg_mode_o (reg_mode),
    .direct_o   (direct),
    .disp_ext_o (disp_ext)
  );

  oploc_offset_calc #(.WORD_W(WORD_W)) u_offs (
    .rm_i       (rm),
    .direct_i   (direct),
    .reg_mode_i (reg_mode),
    .disp_ext_i (disp_ext),
    .bx_i       (bx_i),
    .bp_i       (bp_i),
    .si_i       (si_i),
    .di_i       (di_i),
    .offset_o   (offset),
    .uses_bp_o  (uses_bp)
  );

  oploc_seg_select #(.WORD_W(WORD_W)) u_seg (
    .uses_bp_i  (uses_bp),
    .reg_mode_i (reg_mode),
    .pfx_i      (pfx_i),
    .pfx_vld_i  (pfx_vld_i),
    .es_i       (es_i),
    .cs_i       (cs_i),
    .ss_i       (ss_i),
    .ds_i       (ds_i),
    .code_o     (seg_code),
    .base_o     (seg_base)
  );

  assign reg_idx = reg_mode ? {wide_i, rm} : 4'd0;
  assign reg_sel = {wide_i, regf};

  always_comb begin
    if (reg_mode) phys = '0;
    else          phys = {seg_base, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset};
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          reg_mode_o <= 1'b0;
          reg_idx_o  <= '0;
          reg_sel_o  <= '0;
          offset_o   <= '0;
          seg_code_o <= '0;
          phys_o     <= '0;
        end else begin
          reg_mode_o <= reg_mode;
          reg_idx_o  <= reg_idx;
          reg_sel_o  <= reg_sel;
          offset_o   <= offset;
          seg_code_o <= seg_code;
          phys_o     <= phys;
        end
      end
    end else begin : g_comb
      assign reg_mode_o = reg_mode;
      assign reg_idx_o  = reg_idx;
      assign reg_sel_o  = reg_sel;
      assign offset_o   = offset;
      assign seg_code_o = seg_code;
      assign phys_o     = phys;
    end
  endgenerate

endmodule

// File: rtl/oploc_checker.sv
module oploc_checker #(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter bit OUT_REG   = 1'b1,
  localparam int PHYS_W   = WORD_W + SEG_SHIFT
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        modrm_i,
  input logic              wide_i,
  input logic [WORD_W-1:0] disp_i,
  input logic [WORD_W-1:0] bx_i,
  input logic [WORD_W-1:0] bp_i,
  input logic [WORD_W-1:0] si_i,
  input logic [WORD_W-1:0] di_i,
  input logic [WORD_W-1:0] es_i,
  input logic [WORD_W-1:0] cs_i,
  input logic [WORD_W-1:0] ss_i,
  input logic [WORD_W-1:0] ds_i,
  input logic [7:0]        pfx_i,
  input logic              pfx_vld_i,
  input logic              reg_mode_o,
  input logic [3:0]        reg_idx_o,
  input logic [3:0]        reg_sel_o,
  input logic [WORD_W-1:0] offset_o,
  input logic [1:0]        seg_code_o,
  input logic [PHYS_W-1:0] phys_o
);
  generate
    if (OUT_REG) begin : g_chk
      logic              armed;
      logic [7:0]        modrm_q;
      logic              wide_q;
      logic [WORD_W-1:0] disp_q;
      logic [WORD_W-1:0] es_q, cs_q, ss_q, ds_q;
      logic              hit_q;
      logic [1:0]        rr_q;
      logic [WORD_W-1:0] seg_q;
      logic [PHYS_W-1:0] want_phys;

      always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
        modrm_q <= modrm_i;
        wide_q  <= wide_i;
        disp_q  <= disp_i;
        es_q    <= es_i;
        cs_q    <= cs_i;
        ss_q    <= ss_i;
        ds_q    <= ds_i;
        hit_q   <= pfx_vld_i && (pfx_i[7:5] == 3'b001) && (pfx_i[2:0] == 3'b110);
        rr_q    <= pfx_i[4:3];
      end

      always_comb begin
        case (seg_code_o)
          2'b00:   seg_q = es_q;
          2'b01:   seg_q = cs_q;
          2'b10:   seg_q = ss_q;
          default: seg_q = ds_q;
        endcase
        want_phys = {seg_q, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset_o};
      end

      assert_regflag_R1: assert property (@(posedge clk) disable iff (rst || !armed)
        reg_mode_o == (modrm_q[7:6] == 2'b11));

      assert_idx_mem_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        !reg_mode_o |-> reg_idx_o == 4'd0);

      assert_regsel_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        reg_sel_o == {wide_q, modrm_q[5:3]});

      assert_regzero_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        reg_mode_o |-> (offset_o == '0 && phys_o == '0 && seg_code_o == 2'b11));

      assert_direct_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        (modrm_q[7:6] == 2'b00 && modrm_q[2:0] == 3'b110) |-> offset_o == disp_q);

      assert_override_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        (!reg_mode_o && hit_q) |-> seg_code_o == rr_q);

      assert_phys_R11: assert property (@(posedge clk) disable iff (rst || !armed)
        !reg_mode_o |-> phys_o == want_phys);
    end
  endgenerate

endmodule

bind operand_locator oploc_checker #(
  .WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT), .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/sim_operand_locator.sv
module sim_operand_locator;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  modrm_i;
  logic        wide_i;
  logic [15:0] disp_i, bx_i, bp_i, si_i, di_i, es_i, cs_i, ss_i, ds_i;
  logic [7:0]  pfx_i;
  logic        pfx_vld_i;
  logic        reg_mode_o;
  logic [3:0]  reg_idx_o, reg_sel_o;
  logic [15:0] offset_o;
  logic [1:0]  seg_code_o;
  logic [19:0] phys_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  operand_locator u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference built from the requirement text
  task automatic model(output logic [15:0] offs, output logic [1:0] sc,
                       output logic [19:0] ph);
    logic [15:0] base, dsp, sv;
    logic        bp_form;
    case (modrm_i[2:0])
      3'd0: base = bx_i + si_i;
      3'd1: base = bx_i + di_i;
      3'd2: base = bp_i + si_i;
      3'd3: base = bp_i + di_i;
      3'd4: base = si_i;
      3'd5: base = di_i;
      3'd6: base = bp_i;
      default: base = bx_i;
    endcase
    bp_form = (modrm_i[2:1] == 2'b01) || (modrm_i[2:0] == 3'd6);
    case (modrm_i[7:6])
      2'b01: dsp = {{8{disp_i[7]}}, disp_i[7:0]};
      2'b10: dsp = disp_i;
      default: dsp = 16'd0;
    endcase
    if (modrm_i[7:6] == 2'b00 && modrm_i[2:0] == 3'd6) begin
      base = 16'd0; dsp = disp_i; bp_form = 1'b0;
    end
    offs = base + dsp;
    sc = bp_form ? 2'b10 : 2'b11;
    if (pfx_vld_i && pfx_i[7:5] == 3'b001 && pfx_i[2:0] == 3'b110) sc = pfx_i[4:3];
    case (sc)
      2'b00: sv = es_i; 2'b01: sv = cs_i; 2'b10: sv = ss_i; default: sv = ds_i;
    endcase
    ph = {sv, 4'h0} + {4'h0, offs};
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_regs();
    bx_i = 16'h1234; bp_i = 16'h2000; si_i = 16'h0010; di_i = 16'h0F00;
    es_i = 16'h1000; cs_i = 16'h2000; ss_i = 16'h3000; ds_i = 16'h4000;
  endtask

  task automatic apply_mem(string req, logic [7:0] m, logic [15:0] d);
    logic [15:0] eo; logic [1:0] es; logic [19:0] ep;
    modrm_i = m; disp_i = d;
    model(eo, es, ep);
    step();
    chk({req, " offset"}, 32'(offset_o), 32'(eo));
    chk({req, " seg"}, 32'(seg_code_o), 32'(es));
    chk({req, " phys"}, 32'(phys_o), 32'(ep));
  endtask

  task automatic t_reset();
    rst = 1'b1; modrm_i = 8'hC5; wide_i = 1'b1; disp_i = 16'h7777;
    pfx_i = 8'h00; pfx_vld_i = 1'b0; set_regs();
    repeat (3) step();
    chk("R12 reset mode", 32'(reg_mode_o), 0);
    chk("R12 reset idx", 32'(reg_idx_o), 0);
    chk("R12 reset sel", 32'(reg_sel_o), 0);
    chk("R12 reset offs", 32'(offset_o), 0);
    chk("R12 reset seg", 32'(seg_code_o), 0);
    chk("R12 reset phys", 32'(phys_o), 0);
    rst = 1'b0;
  endtask

  task automatic t_regmode();
    for (int w = 0; w < 2; w++) begin
      for (int r = 0; r < 8; r++) begin
        modrm_i = {2'b11, 3'(7 - r), 3'(r)}; wide_i = w[0];
        step();
        chk("R1 reg flag", 32'(reg_mode_o), 1);
        chk("R2 reg idx", 32'(reg_idx_o), 32'(w * 8 + r));
        chk("R3 reg sel", 32'(reg_sel_o), 32'(w * 8 + 7 - r));
        chk("R4 reg offs", 32'(offset_o), 0);
        chk("R4 reg phys", 32'(phys_o), 0);
        chk("R4 reg seg", 32'(seg_code_o), 3);
      end
    end
  endtask

  task automatic t_base_table();
    for (int md = 0; md < 3; md++) begin
      for (int r = 0; r < 8; r++) begin
        wide_i = r[0];
        apply_mem("R5 table", {2'(md), 3'(r), 3'(r)}, 16'h0102);
        chk("R1 mem flag", 32'(reg_mode_o), 0);
        chk("R2 mem idx", 32'(reg_idx_o), 0);
        chk("R3 mem sel", 32'(reg_sel_o), 32'({r[0], 3'(r)}));
      end
    end
    // spot values: mode 00 BP+DI = 2F00, SS
    apply_mem("R5 bp+di", 8'b00_000_011, 16'hFFFF);
    chk("R5 bp+di literal", 32'(offset_o), 32'h2F00);
    chk("R8 bp+di ss", 32'(seg_code_o), 2);
  endtask

  task automatic t_disp();
    apply_mem("R6 disp8 neg", 8'b01_000_000, 16'hAB80);
    chk("R6 disp8 neg literal", 32'(offset_o), 32'h11C4);
    chk("R11 disp8 phys literal", 32'(phys_o), 32'h411C4);
    apply_mem("R6 disp8 pos", 8'b01_000_100, 16'hFF7F);
    chk("R6 disp8 pos literal", 32'(offset_o), 32'h008F);
    apply_mem("R6 disp16", 8'b10_000_111, 16'hF000);
    chk("R6 disp16 wrap literal", 32'(offset_o), 32'h0234);
    apply_mem("R6 mode00 nodisp", 8'b00_000_101, 16'h5555);
    chk("R6 mode00 literal", 32'(offset_o), 32'h0F00);
  endtask

  task automatic t_direct();
    apply_mem("R7 direct", 8'b00_010_110, 16'hBEEF);
    chk("R7 direct offs", 32'(offset_o), 32'hBEEF);
    chk("R7 direct seg", 32'(seg_code_o), 3);
    apply_mem("R8 bp disp8", 8'b01_010_110, 16'h0004);
    chk("R8 bp disp8 ss", 32'(seg_code_o), 2);
    chk("R8 bp disp8 offs", 32'(offset_o), 32'h2004);
  endtask

  task automatic t_override();
    pfx_vld_i = 1'b1;
    for (int rr = 0; rr < 4; rr++) begin
      pfx_i = {3'b001, 2'(rr), 3'b110};
      apply_mem("R9 override bp", 8'b10_000_010, 16'h0040);
      chk("R9 override bp seg", 32'(seg_code_o), 32'(rr));
      apply_mem("R9 override bx", 8'b00_000_111, 16'h0000);
      chk("R9 override bx seg", 32'(seg_code_o), 32'(rr));
    end
    pfx_vld_i = 1'b0; pfx_i = 8'h00;
  endtask

  task automatic t_prefix_ignore();
    pfx_i = 8'b001_00_110; pfx_vld_i = 1'b0;
    apply_mem("R10 vld low", 8'b00_000_010, 16'h0000);
    chk("R10 vld low seg", 32'(seg_code_o), 2);
    pfx_vld_i = 1'b1;
    pfx_i = 8'b101_01_110;
    apply_mem("R10 bad head", 8'b00_000_100, 16'h0000);
    chk("R10 bad head seg", 32'(seg_code_o), 3);
    pfx_i = 8'b001_00_111;
    apply_mem("R10 bad tail", 8'b01_000_110, 16'h0000);
    chk("R10 bad tail seg", 32'(seg_code_o), 2);
    pfx_vld_i = 1'b0; pfx_i = 8'h00;
  endtask

  task automatic t_phys_wrap();
    ds_i = 16'hFFFF;
    apply_mem("R11 wrap", 8'b00_000_110, 16'h0020);
    chk("R11 wrap literal", 32'(phys_o), 32'h00010);
    set_regs();
  endtask

  task automatic t_latency();
    modrm_i = 8'b00_000_100; disp_i = 16'h0;
    step();
    chk("R12 settle", 32'(offset_o), 32'h0010);
    modrm_i = 8'b00_000_101;
    #1;
    chk("R12 hold before edge", 32'(offset_o), 32'h0010);
    step();
    chk("R12 after edge", 32'(offset_o), 32'h0F00);
    rst = 1'b1;
    step();
    chk("R12 sync reset", 32'(offset_o), 0);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_regmode();
    t_base_table();
    t_disp();
    t_direct();
    t_override();
    t_prefix_ignore();
    t_phys_wrap();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule